// File: doc/BRIEF.md
# S/PDIF Biphase Subframe Transmitter

This block turns a stream of stereo PCM sample pairs into a consumer-format S/PDIF line signal. It runs on a cell clock that is 128 times the sample rate. Each frame takes 128 cycles and carries two subframes of 32 bit slots, and each slot occupies two cells. A subframe opens with an 8-cell sync pattern. After it come the 24-bit audio word (least significant bit first), the validity, user and channel-status flags, and an even-parity bit. Every slot after the sync pattern is biphase-mark coded.

The block requests one sample pair per frame through a valid/ready handshake. A frame counter steps through a 192-frame block. It selects the channel-status bit for each subframe from one 192-bit bank per channel, and it chooses the block-start sync pattern. A select control for each of the validity, user and channel-status flags decides whether the flag comes from a static setting or from the sample stream. Audio is muted by forcing the validity flag to 1 while samples keep flowing. When no pair is offered at a frame boundary, the block repeats the previous pair and latches an underrun flag.

Top module: `spdif_tx`

## Requirements
- R1: After reset and while `tx_en` is low, `spdif_out` is 0, `smp_ready` is 0 and `underrun` is 0.
- R2: While `tx_en` is high, `smp_ready` is high for exactly one cycle in every 128. The first such cycle is the first cycle `tx_en` is high. A pair is taken when `smp_valid` and `smp_ready` are both high, and it is sent in the frame that follows.
- R3: In every slot from 4 to 31, the line level inverts on the first cell. It inverts again on the second cell only when the slot's bit is 1.
- R4: Slots 0 to 3 carry an 8-cell sync pattern, given first cell first for a line that was low before it. The block-start pattern 11101000 opens channel A of frame 0. The pattern 11100010 opens channel A of every other frame. The pattern 11100100 opens every channel B subframe. All cells are inverted when the line was high before the pattern.
- R5: Slots 4 to 27 carry the audio sample, least significant bit in slot 4. Channel A carries `smp_left` and channel B carries `smp_right`.
- R6: Slot 31 makes the count of ones in slots 4 to 31 even.
- R7: Slot 28 (validity) equals `v_manual` when `v_src_stream` is 0. It equals the sample's `smp_vflag` bit for the channel when `v_src_stream` is 1 (bit 0 is channel A). Setting `v_manual` to 1 mutes the output while the audio slots keep carrying samples.
- R8: Slot 29 (user) equals `u_manual` when `u_src_stream` is 0, and the sample's `smp_uflag` bit for the channel when it is 1. Slot 30 (channel status) comes from the sample's `smp_cflag` bit for the channel when `c_src_stream` is 1.
- R9: When `c_src_stream` is 0, slot 30 of frame n in a 192-frame block is bit n of `cs_chan_a` (channel A) or `cs_chan_b` (channel B). Bit 0 is the least significant bit, and frame numbering wraps from 191 to 0.
- R10: If `smp_valid` is low on a ready cycle, the previous pair is sent again and `underrun` goes high. It stays high until reset.
- R11: One cycle after `tx_en` falls, `spdif_out` is 0. When `tx_en` rises again, the block restarts at frame 0 with the block-start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, 128 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Sample pair taken this cycle |
| smp_left | input | 24 | Channel A audio |
| smp_right | input | 24 | Channel B audio |
| smp_vflag | input | 2 | Stream validity flags, bit 0 is channel A |
| smp_uflag | input | 2 | Stream user flags, bit 0 is channel A |
| smp_cflag | input | 2 | Stream channel-status flags, bit 0 is channel A |
| v_src_stream | input | 1 | Validity from the stream (1) or from v_manual (0) |
| u_src_stream | input | 1 | User bit from the stream (1) or from u_manual (0) |
| c_src_stream | input | 1 | Channel status from the stream (1) or from the banks (0) |
| v_manual | input | 1 | Static validity value; 1 mutes |
| u_manual | input | 1 | Static user value |
| cs_chan_a | input | 192 | Channel A status bank, bit n goes with frame n |
| cs_chan_b | input | 192 | Channel B status bank, bit n goes with frame n |
| spdif_out | output | 1 | Biphase-mark line output |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The first stimulus runs more than one full 192-frame block. The two status banks carry different, irregular bit patterns, and every pair holds distinct audio words and flags. This separates left from right, bit order within the audio field, parity, and the mapping from frame number to status bit across the block wrap. A muted stretch and a stretch with all flags sourced from the stream show which flags follow the select controls. A stretch with the user value set and its select cleared isolates the user source. A starvation window shows that the held pair is repeated and that the flag stays latched. A disable in the middle of a frame, followed by a restart, shows the line dropping low and the block-start pattern returning.

// File: rtl/spdif_pkg.sv
package spdif_pkg;
    localparam int AUD_BITS       = 24;
    localparam int SLOT_COUNT     = 32;
    localparam int PRE_SLOTS      = 4;
    localparam int CELLS_PER_SLOT = 2;
    localparam int SUB_PER_FRAME  = 2;
    localparam int PRE_CELLS      = PRE_SLOTS * CELLS_PER_SLOT;
    localparam int SLOT_W         = $clog2(SLOT_COUNT);
    localparam int PCELL_W        = $clog2(PRE_CELLS);

    typedef enum logic [1:0] {
        PRE_BLOCK,
        PRE_CHA,
        PRE_CHB
    } pre_kind_e;

    typedef struct packed {
        logic [AUD_BITS-1:0] left;
        logic [AUD_BITS-1:0] right;
        logic [1:0]          vf;
        logic [1:0]          uf;
        logic [1:0]          cf;
    } pair_t;

    typedef struct packed {
        logic              run;
        logic              sub;
        logic [SLOT_W-1:0] slot;
        logic              half;
    } cell_pos_t;

    // Sync pattern, first cell in the MSB, for a line that was low before it.
    function automatic logic [PRE_CELLS-1:0] pre_pattern(input pre_kind_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_CHA:   return 8'b1110_0010;
            default:   return 8'b1110_0100;
        endcase
    endfunction
endpackage

// File: rtl/spdif_cell_timer.sv
module spdif_cell_timer
    import spdif_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    output cell_pos_t                 pos,
    output logic [$clog2(FRAMES)-1:0] frame_idx,
    output logic                      fetch
);
    localparam int CELLS = SUB_PER_FRAME * SLOT_COUNT * CELLS_PER_SLOT;
    localparam int CW    = $clog2(CELLS);
    localparam int FW    = $clog2(FRAMES);
    localparam logic [CW-1:0] LAST_CELL  = CW'(CELLS - 1);
    localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

    logic [CW-1:0] cc_q;
    logic [FW-1:0] frm_q;
    logic          run_q;

    // Idle parks on the last cell of the last frame, so the first enabled
    // cycle is a fetch and the first sent frame is frame 0.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cc_q  <= LAST_CELL;
            frm_q <= LAST_FRAME;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (cc_q == LAST_CELL) begin
                cc_q  <= '0;
                frm_q <= (frm_q == LAST_FRAME) ? '0 : frm_q + 1'b1;
            end else begin
                cc_q <= cc_q + 1'b1;
            end
        end
    end

    always_comb begin
        pos.run  = run_q;
        pos.sub  = cc_q[CW-1];
        pos.slot = cc_q[CW-2:1];
        pos.half = cc_q[0];
    end

    assign frame_idx = frm_q;
    assign fetch     = en && (cc_q == LAST_CELL);

    // R9: the frame number moves only at a frame boundary
    assert_frame_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (en && cc_q != LAST_CELL) |=> $stable(frm_q));
endmodule

// File: rtl/spdif_sample_src.sv
module spdif_sample_src
    import spdif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fetch,
    input  logic  valid,
    input  pair_t in_pair,
    output logic  ready,
    output pair_t hold,
    output logic  underrun
);
    pair_t hold_q;
    logic  unf_q;

    assign ready    = fetch;
    assign hold     = hold_q;
    assign underrun = unf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            unf_q  <= 1'b0;
        end else if (fetch) begin
            if (valid) hold_q <= in_pair;
            else       unf_q  <= 1'b1;
        end
    end

    assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);

    assert_repeat_pair_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch && !valid) |=> $stable(hold_q));
endmodule

// File: rtl/spdif_subframe_word.sv
module spdif_subframe_word
    import spdif_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  pair_t                     hold,
    input  logic                      sub,
    input  logic [$clog2(FRAMES)-1:0] frame_idx,
    input  logic [FRAMES-1:0]         cs_a,
    input  logic [FRAMES-1:0]         cs_b,
    input  logic                      sel_v,
    input  logic                      sel_u,
    input  logic                      sel_c,
    input  logic                      man_v,
    input  logic                      man_u,
    output logic [SLOT_COUNT-1:0]     word
);
    localparam int PAY_W = SLOT_COUNT - 1 - PRE_SLOTS;

    logic [AUD_BITS-1:0] aud;
    logic                vb, ub, cb, bank_bit;
    logic [PAY_W-1:0]    pay;

    always_comb begin
        aud      = sub ? hold.right : hold.left;
        bank_bit = sub ? cs_b[frame_idx] : cs_a[frame_idx];
        vb       = sel_v ? hold.vf[sub] : man_v;
        ub       = sel_u ? hold.uf[sub] : man_u;
        cb       = sel_c ? hold.cf[sub] : bank_bit;
        pay      = {cb, ub, vb, aud};
        word     = {^pay, pay, {PRE_SLOTS{1'b0}}};
    end
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
    import spdif_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  cell_pos_t             pos,
    input  logic                  block_first,
    input  logic [SLOT_COUNT-1:0] word,
    output logic                  line
);
    localparam logic [PCELL_W-1:0] PC_TOP = PCELL_W'(PRE_CELLS - 1);

    logic                 line_q, pol_q, ref_lvl, nxt, is_pre, bit_v;
    logic [PCELL_W-1:0]   pcell;
    pre_kind_e            kind;
    logic [PRE_CELLS-1:0] pat;

    always_comb begin
        is_pre  = pos.slot < SLOT_W'(PRE_SLOTS);
        pcell   = {pos.slot[PCELL_W-2:0], pos.half};
        kind    = pos.sub ? PRE_CHB : (block_first ? PRE_BLOCK : PRE_CHA);
        pat     = pre_pattern(kind);
        ref_lvl = (pcell == '0) ? line_q : pol_q;
        bit_v   = word[pos.slot];
        if (is_pre)        nxt = pat[PC_TOP - pcell] ^ ref_lvl;
        else if (!pos.half) nxt = ~line_q;
        else               nxt = line_q ^ bit_v;
    end

    always_ff @(posedge clk) begin
        if (rst || !pos.run) begin
            line_q <= 1'b0;
            pol_q  <= 1'b0;
        end else begin
            line_q <= nxt;
            if (is_pre && pcell == '0) pol_q <= line_q;
        end
    end

    assign line = line_q;

    assert_slot_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (pos.run && !is_pre && !pos.half) |=> (line_q != $past(line_q)));

    assert_zero_no_mid_R3: assert property (@(posedge clk) disable iff (rst)
        (pos.run && !is_pre && pos.half && !bit_v) |=> $stable(line_q));

    assert_sync_open_R4: assert property (@(posedge clk) disable iff (rst)
        (pos.run && is_pre && pcell == '0) |=> (line_q != $past(line_q)));
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_en,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [AUD_BITS-1:0] smp_left,
    input  logic [AUD_BITS-1:0] smp_right,
    input  logic [1:0]          smp_vflag,
    input  logic [1:0]          smp_uflag,
    input  logic [1:0]          smp_cflag,
    input  logic                v_src_stream,
    input  logic                u_src_stream,
    input  logic                c_src_stream,
    input  logic                v_manual,
    input  logic                u_manual,
    input  logic [FRAMES-1:0]   cs_chan_a,
    input  logic [FRAMES-1:0]   cs_chan_b,
    output logic                spdif_out,
    output logic                underrun
);
    localparam int FW = $clog2(FRAMES);

    cell_pos_t             pos;
    logic [FW-1:0]         frame_idx;
    logic                  fetch;
    pair_t                 in_pair, hold;
    logic [SLOT_COUNT-1:0] word;

    assign in_pair = '{left: smp_left, right: smp_right,
                       vf: smp_vflag, uf: smp_uflag, cf: smp_cflag};

    spdif_cell_timer #(.FRAMES(FRAMES)) u_timer (
        .clk(clk), .rst(rst), .en(tx_en),
        .pos(pos), .frame_idx(frame_idx), .fetch(fetch)
    );

    spdif_sample_src u_src (
        .clk(clk), .rst(rst), .fetch(fetch), .valid(smp_valid),
        .in_pair(in_pair), .ready(smp_ready), .hold(hold), .underrun(underrun)
    );

    spdif_subframe_word #(.FRAMES(FRAMES)) u_word (
        .hold(hold), .sub(pos.sub), .frame_idx(frame_idx),
        .cs_a(cs_chan_a), .cs_b(cs_chan_b),
        .sel_v(v_src_stream), .sel_u(u_src_stream), .sel_c(c_src_stream),
        .man_v(v_manual), .man_u(u_manual), .word(word)
    );

    spdif_bmc_enc u_enc (
        .clk(clk), .rst(rst), .pos(pos), .block_first(frame_idx == '0),
        .word(word), .line(spdif_out)
    );

    assert_idle_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !smp_ready);

    assert_idle_line_R11: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !pos.run) |=> !spdif_out);
endmodule

// File: tb/sim_spdif_tx.sv
module sim_spdif_tx;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst, tx_en, smp_valid, smp_ready;
    logic [23:0]  smp_left, smp_right;
    logic [1:0]   smp_vflag, smp_uflag, smp_cflag;
    logic         v_src_stream, u_src_stream, c_src_stream, v_manual, u_manual;
    logic [191:0] cs_chan_a, cs_chan_b;
    logic         spdif_out, underrun;

    spdif_tx u0 (.*);

    int total = 0, bad = 0, cyc = 0, idx = 0;
    bit done = 0;

    // behavioural reference state
    int       m_cc, m_frm;
    bit       m_run, m_line, m_pol, m_unf, exp_ready, exp_line;
    bit [23:0] hL, hR;
    bit [1:0] hv, hu, hc;
    string    line_tag;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic bit data_bit(int sub, int slot);
        bit [23:0] a = sub ? hR : hL;
        if (slot <= 27) return a[slot-4];
        if (slot == 28) return v_src_stream ? hv[sub] : v_manual;
        if (slot == 29) return u_src_stream ? hu[sub] : u_manual;
        return c_src_stream ? hc[sub] : (sub ? cs_chan_b[m_frm] : cs_chan_a[m_frm]);
    endfunction

    task automatic apply_src();
        smp_left  = 24'(idx * 32'h0002_9C4B + 32'h0005_A5A5);
        smp_right = 24'((idx * 32'h000D_1337) ^ 32'h00F0_F00F);
        smp_vflag = 2'(idx);
        smp_uflag = 2'(idx >> 1);
        smp_cflag = 2'(idx >> 2);
    endtask

    task automatic model_step();
        if (rst) begin
            m_cc = 127; m_frm = 191; m_run = 0; m_line = 0; m_pol = 0;
            m_unf = 0; hL = 0; hR = 0; hv = 0; hu = 0; hc = 0;
            line_tag = "R1";
        end else begin
            if (m_run) begin
                int sub = m_cc / 64, c = m_cc % 64, slot = (m_cc % 64) / 2;
                if (slot < 4) begin
                    bit [7:0] pat = sub ? 8'b11100100 : (m_frm == 0 ? 8'b11101000 : 8'b11100010);
                    if (c == 0) m_pol = m_line;
                    m_line = pat[7-c] ^ m_pol;
                    line_tag = "R4";
                end else begin
                    bit b;
                    if (slot == 31) begin
                        b = 0;
                        for (int s = 4; s <= 30; s++) b ^= data_bit(sub, s);
                    end else b = data_bit(sub, slot);
                    if (c % 2 == 0) m_line = !m_line;
                    else if (b) m_line = !m_line;
                    line_tag = slot <= 27 ? "R3 R5" : slot == 28 ? "R3 R7" :
                               slot == 29 ? "R3 R8" : slot == 30 ? "R3 R8 R9" : "R3 R6";
                end
            end else begin
                m_line = 0; m_pol = 0; line_tag = "R11";
            end
            if (!tx_en) begin
                m_cc = 127; m_frm = 191; m_run = 0;
            end else begin
                m_run = 1;
                if (m_cc == 127) begin
                    if (smp_valid) begin
                        hL = smp_left; hR = smp_right;
                        hv = smp_vflag; hu = smp_uflag; hc = smp_cflag;
                    end else m_unf = 1;
                    m_cc = 0;
                    m_frm = (m_frm == 191) ? 0 : m_frm + 1;
                end else m_cc++;
            end
        end
        exp_line = m_line;
    endtask

    task automatic tick();
        bit took;
        #1;
        exp_ready = !rst && tx_en && (m_cc == 127);
        chk(smp_ready === exp_ready, "R2 ready", int'(smp_ready), int'(exp_ready));
        took = exp_ready && smp_valid;
        model_step();
        @(negedge clk);
        chk(spdif_out === exp_line, line_tag, int'(spdif_out), int'(exp_line));
        chk(underrun === m_unf, "R10 underrun", int'(underrun), int'(m_unf));
        if (took) begin idx++; apply_src(); end
    endtask

    task automatic run_frames(int n);
        for (int i = 0; i < n * 128; i++) tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        rst = 1; tx_en = 0; smp_valid = 0;
        v_src_stream = 0; u_src_stream = 0; c_src_stream = 0;
        v_manual = 0; u_manual = 0;
        cs_chan_a = {6{32'hC3A5_1E0F}} ^ {192'h0};
        cs_chan_b = {3{64'h0F1E_2D3C_8877_9AB5}};
        cs_chan_a[191] = 1'b1; cs_chan_a[0] = 1'b0; cs_chan_b[0] = 1'b1;
        m_cc = 127; m_frm = 191;
        apply_src();
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        // R1: idle after reset
        for (int i = 0; i < 4; i++) tick();
        chk(spdif_out === 1'b0, "R1 line", int'(spdif_out), 0);
        chk(smp_ready === 1'b0, "R1 ready", int'(smp_ready), 0);
        chk(underrun === 1'b0, "R1 underrun", int'(underrun), 0);
        // R5 R6 R9: beyond one full block with bank status
        smp_valid = 1; tx_en = 1;
        tick();
        run_frames(200);
        // R7: mute via manual validity
        v_manual = 1;
        run_frames(8);
        // R7 R8: all flags from the stream
        v_manual = 0; v_src_stream = 1; u_src_stream = 1; c_src_stream = 1; u_manual = 1;
        run_frames(16);
        // R8: manual user bit set
        v_src_stream = 0; u_src_stream = 0; c_src_stream = 0;
        run_frames(4);
        // R10: starvation
        smp_valid = 0;
        run_frames(3);
        smp_valid = 1;
        run_frames(4);
        chk(underrun === 1'b1, "R10 sticky", int'(underrun), 1);
        // R11: disable mid-frame and restart
        for (int i = 0; i < 37; i++) tick();
        tx_en = 0;
        for (int i = 0; i < 50; i++) tick();
        chk(spdif_out === 1'b0, "R11 idle line", int'(spdif_out), 0);
        tx_en = 1;
        tick();
        run_frames(6);
        finish_run();
    end
endmodule